// File: doc/BRIEF.md
# JTAG Multi-Sequence Shift Engine

The engine plays out one JTAG shift transaction made of a list of sequences. Upstream logic writes the request bytes into the engine one per cycle: first a count of sequences, then for each sequence a header byte followed by its TDI data bytes. The engine walks the stored bytes and starts only once every declared sequence is fully present. Until then it keeps waiting for more bytes.

During execution the engine drives TMS, TDI and TCK itself. A half-period input sets the clock timing, so one cycle of the system clock is the finest step. Sequences with the capture flag set sample TDO on every bit and pack the samples into response bytes. The response stream starts with a fixed tag byte and a zero status byte, then carries the captured bytes, and is closed by a one-cycle done pulse. Frame length checks are made upstream, and a request is assumed to fit the buffer.

Top module: `jseq_engine`

## Requirements
- R1: After reset, tck_o, tms_o, tdi_o, resp_vld_o and done_o are all low.
- R2: No TCK edge and no response byte appear until the buffer holds the count byte plus every header and data byte the count declares; bytes are accepted only while the engine is waiting for a request.
- R3: A header byte holds the bit count in bits [5:0] (value 0 means 64 bits), the TMS level for the whole sequence in bit 6 and the capture flag in bit 7; tms_o holds the bit-6 level at every rising TCK of that sequence.
- R4: Each sequence consumes ceil(n/8) data bytes after its header; TDI bit i is bit (i mod 8) of data byte (i div 8), so bits go out least significant first, and the next header follows directly.
- R5: TCK stays high for exactly half_per_i+1 clock cycles per bit, and TDI/TMS are stable for at least half_per_i+1 cycles before each rising TCK and while TCK is high.
- R6: TDO is sampled in the first clock cycle after TCK rises.
- R7: A capturing sequence adds ceil(n/8) response bytes; sample i lands in bit (i mod 8) of byte (i div 8), and unused high bits of the last byte are zero. A non-capturing sequence adds no bytes.
- R8: The response stream is RESP_TAG, then status 0x00, then the captured bytes in sequence order, each on a one-cycle resp_vld_o strobe.
- R9: done_o pulses for one cycle after the last response byte, never in the same cycle as a response byte, and the next request may then be written.
- R10: A sequence count of 0 yields only the tag and status bytes and done, with no TCK activity.
- R11: TCK is low when execution starts, between bits, and when done_o pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_wr_i | input | 1 | Request byte strobe |
| req_byte_i | input | 8 | Request byte |
| half_per_i | input | HPW | TCK half period minus one, in clock cycles; held stable during a request |
| tdo_i | input | 1 | Test data from the target |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the target |
| resp_vld_o | output | 1 | Response byte strobe |
| resp_byte_o | output | 8 | Response byte |
| done_o | output | 1 | Request finished, one-cycle pulse |

## Verification
Two events can meet in the same cycle. The first is a request byte being written. The second is the completeness scanner comparing its offset against the byte count. To provoke this, the multi-sequence request is fed with idle gaps between bytes, and the bench checks that neither TCK nor the response moves before the final byte lands. The same bench also checks that a captured byte completed by the eighth sample does not collide with a tail flush or with the done pulse. It does this by comparing every response strobe with a queue built from the header rules, and by requiring the queue to be empty when done rises.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

  typedef enum logic [2:0] {
    T_SCAN, T_CMD, T_STAT, T_HDR, T_BIT, T_WAIT, T_DONE
  } top_st_e;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_st_e;

  typedef struct packed {
    logic       cap;
    logic       tms;
    logic [5:0] len;
  } seq_hdr_t;

  function automatic logic [6:0] hdr_bits(input logic [5:0] len);
    return (len == 6'd0) ? 7'd64 : {1'b0, len};
  endfunction

  function automatic logic [3:0] bits_to_bytes(input logic [6:0] n);
    logic [6:0] r;
    r = (n + 7'd7) >> 3;
    return r[3:0];
  endfunction

endpackage

// File: rtl/jseq_buf.sv
module jseq_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] cnt_o
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          push;

  assign push = wr_i && !clr_i && (cnt_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (push)   cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[cnt_q[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign cnt_o     = cnt_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/jseq_scan.sv
module jseq_scan import jseq_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int OW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          ready_o
);
  logic          have_n_q, rdy_q;
  logic [7:0]    left_q;
  logic [OW-1:0] off_q;
  logic [OW-1:0] cnt_w;

  assign cnt_w = OW'(cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_n_q <= 1'b0;
      rdy_q    <= 1'b0;
      left_q   <= '0;
      off_q    <= '0;
    end else if (clr_i) begin
      have_n_q <= 1'b0;
      rdy_q    <= 1'b0;
      left_q   <= '0;
      off_q    <= '0;
    end else if (en_i && !rdy_q) begin
      if (!have_n_q) begin
        if (cnt_i != '0) begin
          have_n_q <= 1'b1;
          left_q   <= rd_data_i;
          off_q    <= OW'(1);
        end
      end else if (left_q == 8'd0) begin
        if (off_q <= cnt_w) rdy_q <= 1'b1;
      end else if (off_q < cnt_w) begin
        // header present: skip it and its data bytes
        left_q <= left_q - 8'd1;
        off_q  <= off_q + OW'(1) + OW'(bits_to_bytes(hdr_bits(rd_data_i[5:0])));
      end
    end
  end

  assign rd_addr_o = have_n_q ? off_q[AW-1:0] : '0;
  assign ready_o   = rdy_q;

  // R2
  rdy_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cnt_i != '0));

endmodule

// File: rtl/jseq_shift.sv
module jseq_shift import jseq_pkg::*; #(
  parameter int HPW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [HPW-1:0] hp_i,
  output logic           tck_o,
  output logic           smp_o,
  output logic           done_o
);
  sh_st_e         st_q;
  logic [HPW-1:0] cnt_q;
  logic           tck_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      tck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SH_IDLE: if (go_i) begin
          st_q  <= SH_LOW;
          cnt_q <= '0;
        end
        SH_LOW: if (cnt_q == hp_i) begin
          st_q  <= SH_HIGH;
          cnt_q <= '0;
          tck_q <= 1'b1;
        end else cnt_q <= cnt_q + HPW'(1);
        SH_HIGH: if (cnt_q == hp_i) begin
          st_q   <= SH_IDLE;
          cnt_q  <= '0;
          tck_q  <= 1'b0;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q + HPW'(1);
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign tck_o  = tck_q;
  assign smp_o  = (st_q == SH_HIGH) && (cnt_q == '0);
  assign done_o = done_q;

  // R6
  smp_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |-> tck_o);

  // R11
  go_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (st_q == SH_IDLE) && !tck_o);

  // R5
  rise_from_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tck_o) |-> $past(st_q == SH_LOW));

endmodule

// File: rtl/jseq_pack.sv
module jseq_pack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic       bit_i,
  input  logic       flush_i,
  output logic       vld_o,
  output logic [7:0] byte_o
);
  logic [2:0] pos_q;
  logic [7:0] acc_q, byte_q;
  logic       vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      acc_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (smp_i) begin
        if (pos_q == 3'd7) begin
          byte_q <= {bit_i, acc_q[6:0]};
          vld_q  <= 1'b1;
          acc_q  <= '0;
          pos_q  <= '0;
        end else begin
          acc_q[pos_q] <= bit_i;
          pos_q        <= pos_q + 3'd1;
        end
      end else if (flush_i && pos_q != 3'd0) begin
        byte_q <= acc_q;
        vld_q  <= 1'b1;
        acc_q  <= '0;
        pos_q  <= '0;
      end
    end
  end

  assign vld_o  = vld_q;
  assign byte_o = byte_q;

  // R7
  flush_vs_smp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_i && flush_i));

endmodule

// File: rtl/jseq_engine.sv
module jseq_engine import jseq_pkg::*; #(
  parameter int          DEPTH    = 64,
  parameter int          HPW      = 16,
  parameter logic [7:0]  RESP_TAG = 8'h5C,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_wr_i,
  input  logic [7:0]     req_byte_i,
  input  logic [HPW-1:0] half_per_i,
  input  logic           tdo_i,
  output logic           tck_o,
  output logic           tms_o,
  output logic           tdi_o,
  output logic           resp_vld_o,
  output logic [7:0]     resp_byte_o,
  output logic           done_o
);
  top_st_e       st_q;
  logic [CW-1:0] buf_cnt;
  logic [AW-1:0] rd_addr, scan_addr;
  logic [7:0]    rd_data;
  logic          scan_rdy;
  logic          sh_go, sh_smp, sh_done, sh_tck;
  logic          pk_vld, flush;
  logic [7:0]    pk_byte;
  logic [AW-1:0] ptr_q, dptr_q;
  logic [7:0]    left_q;
  logic [6:0]    nbits_q, bidx_q;
  logic          tms_q, tdi_q, cap_q;
  logic          tag_vld_q, done_q;
  logic [7:0]    tag_q;
  logic          last_bit;
  seq_hdr_t      hdr;

  assign hdr      = seq_hdr_t'(rd_data);
  assign last_bit = (bidx_q + 7'd1) == nbits_q;
  assign sh_go    = (st_q == T_BIT);
  assign flush    = (st_q == T_WAIT) && sh_done && last_bit && cap_q;

  always_comb begin
    unique case (st_q)
      T_SCAN:  rd_addr = scan_addr;
      T_HDR:   rd_addr = ptr_q;
      T_BIT:   rd_addr = dptr_q + AW'(bidx_q[6:3]);
      default: rd_addr = '0;
    endcase
  end

  jseq_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i, .rst_ni,
    .clr_i     (st_q == T_DONE),
    .wr_i      (req_wr_i && st_q == T_SCAN),
    .wr_data_i (req_byte_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .cnt_o     (buf_cnt)
  );

  jseq_scan #(.DEPTH(DEPTH)) i_scan (
    .clk_i, .rst_ni,
    .clr_i     (st_q == T_DONE),
    .en_i      (st_q == T_SCAN),
    .cnt_i     (buf_cnt),
    .rd_data_i (rd_data),
    .rd_addr_o (scan_addr),
    .ready_o   (scan_rdy)
  );

  jseq_shift #(.HPW(HPW)) i_shift (
    .clk_i, .rst_ni,
    .go_i   (sh_go),
    .hp_i   (half_per_i),
    .tck_o  (sh_tck),
    .smp_o  (sh_smp),
    .done_o (sh_done)
  );

  jseq_pack i_pack (
    .clk_i, .rst_ni,
    .smp_i   (sh_smp && cap_q),
    .bit_i   (tdo_i),
    .flush_i (flush),
    .vld_o   (pk_vld),
    .byte_o  (pk_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= T_SCAN;
      ptr_q     <= '0;
      dptr_q    <= '0;
      left_q    <= '0;
      nbits_q   <= '0;
      bidx_q    <= '0;
      tms_q     <= 1'b0;
      tdi_q     <= 1'b0;
      cap_q     <= 1'b0;
      tag_vld_q <= 1'b0;
      tag_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      tag_vld_q <= 1'b0;
      done_q    <= 1'b0;
      unique case (st_q)
        T_SCAN: if (scan_rdy) st_q <= T_CMD;
        T_CMD: begin
          tag_vld_q <= 1'b1;
          tag_q     <= RESP_TAG;
          st_q      <= T_STAT;
        end
        T_STAT: begin
          tag_vld_q <= 1'b1;
          tag_q     <= 8'h00;
          left_q    <= rd_data;
          ptr_q     <= AW'(1);
          st_q      <= (rd_data == 8'd0) ? T_DONE : T_HDR;
        end
        T_HDR: begin
          tms_q   <= hdr.tms;
          cap_q   <= hdr.cap;
          nbits_q <= hdr_bits(hdr.len);
          dptr_q  <= ptr_q + AW'(1);
          bidx_q  <= '0;
          st_q    <= T_BIT;
        end
        T_BIT: begin
          tdi_q <= rd_data[bidx_q[2:0]];
          st_q  <= T_WAIT;
        end
        T_WAIT: if (sh_done) begin
          if (last_bit) begin
            ptr_q  <= dptr_q + AW'(bits_to_bytes(nbits_q));
            left_q <= left_q - 8'd1;
            st_q   <= (left_q == 8'd1) ? T_DONE : T_HDR;
          end else begin
            bidx_q <= bidx_q + 7'd1;
            st_q   <= T_BIT;
          end
        end
        T_DONE: begin
          done_q <= 1'b1;
          st_q   <= T_SCAN;
        end
        default: st_q <= T_SCAN;
      endcase
    end
  end

  assign tck_o       = sh_tck;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign resp_vld_o  = tag_vld_q | pk_vld;
  assign resp_byte_o = tag_vld_q ? tag_q : pk_byte;
  assign done_o      = done_q;

  // R8
  resp_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tag_vld_q && pk_vld));

  // R5
  pins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> $stable(tdi_o) && $stable(tms_o));

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !resp_vld_o && !tck_o);

  // R2
  idle_tck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_SCAN) |-> !tck_o);

endmodule

// File: tb/test_jseq_engine.sv
module test_jseq_engine;
  localparam int CLK_PER = 10;
  localparam int DEPTH   = 64;
  localparam int HPW     = 16;
  localparam logic [7:0] TAG = 8'h5C;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_wr = 1'b0;
  logic [7:0]     req_byte = '0;
  logic [HPW-1:0] half_per = '0;
  logic           tdo;
  logic           tck, tms, tdi, resp_vld, done;
  logic [7:0]     resp_byte;

  int total = 0, bad = 0;
  logic [1:0] pin_q[$];
  logic [7:0] resp_q[$];
  int exp_hp = 0, gidx = 0, tdo_idx = 0;
  int rises = 0, resp_seen = 0, hi_run = 0, lo_run = 0;
  logic tck_prev = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic tdo_fn(input int k);
    return logic'(((k >> 1) ^ ((k % 3) == 0 ? 1 : 0)) & 1);
  endfunction

  assign tdo = tdo_fn(tdo_idx);
  always @(negedge tck) tdo_idx++;

  jseq_engine #(.DEPTH(DEPTH), .HPW(HPW), .RESP_TAG(TAG)) i_jseq_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_wr_i(req_wr), .req_byte_i(req_byte),
    .half_per_i(half_per), .tdo_i(tdo), .tck_o(tck), .tms_o(tms), .tdi_o(tdi),
    .resp_vld_o(resp_vld), .resp_byte_o(resp_byte), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pins and response against scoreboard queues
  always @(negedge clk) if (rst_n) begin
    if (tck && !tck_prev) begin
      rises++;
      if (pin_q.size() == 0) chk(0, "R2 unexpected tck", 1, 0);
      else begin
        logic [1:0] e;
        e = pin_q.pop_front();
        chk(tms == e[1], "R3 tms", int'(tms), int'(e[1]));
        chk(tdi == e[0], "R4 tdi", int'(tdi), int'(e[0]));
      end
      chk(lo_run >= exp_hp + 1, "R5 low width", lo_run, exp_hp + 1);
      hi_run = 1;
      lo_run = 0;
    end else if (tck) hi_run++;
    if (!tck && tck_prev) begin
      chk(hi_run == exp_hp + 1, "R5 high width", hi_run, exp_hp + 1);
      lo_run = 0;
    end
    if (!tck) lo_run++;
    if (resp_vld) begin
      resp_seen++;
      if (resp_q.size() == 0) chk(0, "R8 extra byte", int'(resp_byte), 0);
      else begin
        logic [7:0] eb;
        eb = resp_q.pop_front();
        // R6 R7 captured data
        chk(resp_byte == eb, "R8 R7 resp byte", int'(resp_byte), int'(eb));
      end
    end
    tck_prev = tck;
  end

  task automatic run_req(input logic [7:0] b[$], input int hp, input int gap, input bit hold_last);
    int off, r0, s0, nb, nseq;
    logic [7:0] h, acc;
    exp_hp   = hp;
    half_per = HPW'(hp);
    resp_q.push_back(TAG);
    resp_q.push_back(8'h00);
    nseq = int'(b[0]);
    off  = 1;
    for (int s = 0; s < nseq; s++) begin
      h   = b[off];
      nb  = (h[5:0] == 6'd0) ? 64 : int'(h[5:0]);
      acc = '0;
      for (int i = 0; i < nb; i++) begin
        logic [7:0] d;
        d = b[off + 1 + i / 8];
        pin_q.push_back({h[6], d[i % 8]});
        if (h[7]) begin
          acc[i % 8] = tdo_fn(gidx);
          if (i % 8 == 7) begin resp_q.push_back(acc); acc = '0; end
        end
        gidx++;
      end
      if (h[7] && (nb % 8) != 0) resp_q.push_back(acc);
      off += 1 + (nb + 7) / 8;
    end
    r0 = rises;
    s0 = resp_seen;
    for (int k = 0; k < b.size(); k++) begin
      if (hold_last && k == b.size() - 1) begin
        repeat (12) @(negedge clk);
        chk(rises == r0 && resp_seen == s0, "R2 early start", rises - r0, 0);
      end
      @(negedge clk);
      req_wr   = 1'b1;
      req_byte = b[k];
      @(negedge clk);
      req_wr = 1'b0;
      repeat (gap) @(negedge clk);
    end
    for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(resp_q.size() == 0, "R9 bytes before done", resp_q.size(), 0);
    chk(pin_q.size() == 0, "R4 all bits shifted", pin_q.size(), 0);
    chk(tck == 1'b0, "R11 tck low at done", int'(tck), 0);
    chk(resp_vld == 1'b0, "R9 done alone", int'(resp_vld), 0);
    if (nseq == 0) chk(rises == r0, "R10 no tck", rises - r0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 one-cycle done", int'(done), 0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // R1
    chk(!tck && !tms && !tdi && !resp_vld && !done, "R1 reset outputs",
        int'({tck, tms, tdi, resp_vld, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 empty request
    q = '{8'h00};
    run_req(q, 0, 0, 1'b0);
    // R3 tms high, 5 bits, no capture
    q = '{8'h01, 8'h45, 8'h1B};
    run_req(q, 0, 0, 1'b0);
    // R3 length 0 means 64, capture on
    q = '{8'h01, 8'h80, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    run_req(q, 1, 0, 1'b0);
    // R2 R7 mixed sequences, gapped feed, last byte held back
    q = '{8'h03, 8'h8C, 8'h5A, 8'h03, 8'h43, 8'h05, 8'h89, 8'hF0, 8'h01};
    run_req(q, 2, 2, 1'b1);
    // R6 exact byte capture, slower clock
    q = '{8'h01, 8'hC8, 8'hA7};
    run_req(q, 3, 1, 1'b1);
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule